// File: doc/BRIEF.md
# Sampling Tap Correction Engine

This block runs once a hardware delay-tap tuning pass has finished and chooses the sampling tap that is actually used. It receives the tap range that the hardware tuner reported (start and end) and the tap that the tuner selected. It also receives three precomputed limits: an upper width threshold, a lower width threshold and a fixed edge offset. From these it first decides whether the tuner's choice can be trusted. A choice is suspect when the reported window touches either end of the tuning range, or when the window is too wide to be a single eye.

When correction is needed, the engine fetches the tuning pass/fail bitmap one 32-bit word at a time over a simple request/valid handshake. It walks the bits in tap order and looks for a passing window that opens after a failure and closes at a later failure. Windows that are too narrow (bubbles) or too wide (merged eyes) are skipped. The first acceptable window sets the tap at its middle. If no window qualifies, the tap is placed at a fixed offset from the first fail-to-pass edge. If no such edge exists, the tuner's tap is kept.

Top module: `tune_fix_engine`

## Requirements
- R1: After reset, busy, done and word_req are low and tap_out is 0.
- R2: On a start pulse, correction is skipped when none of the following holds: hw_start_tap equals 0; hw_end_tap equals the last tap (127 when long_run=0, 255 when long_run=1) or the tap one below it; hw_end_tap−hw_start_tap (8-bit) is at least thr_hi. When skipped, tap_out takes hw_cur_tap, done pulses, and no word is requested.
- R3: When correction runs, words are requested with word_sel counting up from 0, at most 4 words (long_run=0) or 8 words (long_run=1). word_req holds word_sel steady until word_vld is seen. Bit b of word w stands for tap w*32+b, and bits are scanned from bit 0 upward.
- R4: A passing window opens at a pass that follows an earlier fail, and closes at the next fail (end = that tap−1). At the next pass after a closed window, its width end−start is computed. A width w with thr_lo ≤ w < thr_hi is accepted: tap_out = start + w/2, and no further word is requested.
- R5: A closed window whose width is below thr_lo or at least thr_hi is discarded. The new window start becomes the current passing tap, and scanning continues.
- R6: If the bitmap holds no fail bit, tap_out = hw_cur_tap.
- R7: If no window is accepted, a fail was seen and a pass came later, then with F the first fail tap and P the first pass after it, edge = F + (P−F)/2. If edge−1 > fix_ofs (with edge=0 never satisfying it), tap_out = edge−fix_ofs; otherwise tap_out = edge+fix_ofs (8-bit). F and P are captured only once per run.
- R8: If a fail is seen but no pass follows it, tap_out = hw_cur_tap.
- R9: busy rises the cycle after an accepted start and falls right after done. done is a single-cycle pulse with tap_out valid in it. tap_out holds its value until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| long_run | input | 1 | 0: 128-tap pass, 1: 256-tap pass |
| hw_start_tap | input | 8 | First tap of the tuner's window |
| hw_end_tap | input | 8 | Last tap of the tuner's window |
| hw_cur_tap | input | 8 | Tap picked by the tuner |
| thr_hi | input | 8 | Merged-window width limit |
| thr_lo | input | 8 | Bubble-window width limit |
| fix_ofs | input | 8 | Offset from a lone edge |
| word_req | output | 1 | Bitmap word request |
| word_sel | output | 3 | Index of requested word |
| word_vld | input | 1 | Requested word is on word_data |
| word_data | input | 32 | Bitmap word, bit 0 = lowest tap |
| busy | output | 1 | Run in progress |
| done | output | 1 | Result pulse |
| tap_out | output | 8 | Chosen tap |

## Verification
Two decisions can fall due on the same bit: accepting a window, which happens when a pass reopens after a closed window, and the end-of-bitmap fallback. Both are pending when that reopening pass sits on the very last tap. Directed bitmaps put the reopening pass on tap 127 twice. In one the closed window is in range, and the accepted mid-tap must win. In the other it is out of range, and the fallback edge must be produced. A third bitmap places the first pass itself on tap 127, so the edge capture happens on the last scanned bit. The bench compares each result with its own model, and also checks the number of words fetched.

// File: rtl/tfe_pkg.sv
package tfe_pkg;
  localparam int TFE_TAP_W = 8;
  typedef logic [TFE_TAP_W-1:0] tap_t;

  // correction needed when the tuner's window is suspect
  function automatic logic tfe_need(tap_t s, tap_t e, tap_t hi, tap_t last);
    tap_t w;
    w = e - s;
    return (s == '0) || (e == last) || (e == tap_t'(last - 1'b1)) || (w >= hi);
  endfunction

  function automatic logic tfe_win_ok(tap_t w, tap_t hi, tap_t lo);
    return (w < hi) && (w >= lo);
  endfunction

  function automatic tap_t tfe_mid(tap_t st, tap_t w);
    return st + (w >> 1);
  endfunction

  function automatic tap_t tfe_edge_pick(tap_t ff, tap_t fp, tap_t ofs);
    tap_t ed;
    ed = ff + ((fp - ff) >> 1);
    if (ed != '0 && tap_t'(ed - 1'b1) > ofs) return ed - ofs;
    return ed + ofs;
  endfunction
endpackage

// File: rtl/tfe_scan.sv
module tfe_scan
  import tfe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic pass_bit,
  input  tap_t cur_tap,
  input  tap_t thr_hi,
  input  tap_t thr_lo,
  output logic acc,
  output tap_t acc_tap,
  output logic ff_seen,
  output logic fp_seen,
  output tap_t ff_tap,
  output tap_t fp_tap
);
  logic sf_q, sp_q, ep_q;
  tap_t fft_q, fpt_q, spt_q, ept_q;
  tap_t win;
  logic ev_first_fail, ev_open, ev_close, ev_reopen, rej;

  assign ev_first_fail = step && !pass_bit && !sf_q;
  assign ev_open       = step &&  pass_bit &&  sf_q && !sp_q;
  assign ev_close      = step && !pass_bit &&  sf_q &&  sp_q && !ep_q;
  assign ev_reopen     = step &&  pass_bit &&  sp_q &&  ep_q;
  assign win     = ept_q - spt_q;
  assign acc     = ev_reopen &&  tfe_win_ok(win, thr_hi, thr_lo);
  assign rej     = ev_reopen && !tfe_win_ok(win, thr_hi, thr_lo);
  assign acc_tap = tfe_mid(spt_q, win);

  assign ff_seen = sf_q;
  assign fp_seen = sp_q;
  assign ff_tap  = fft_q;
  assign fp_tap  = fpt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sf_q <= 1'b0; sp_q <= 1'b0; ep_q <= 1'b0;
      fft_q <= '0; fpt_q <= '0; spt_q <= '0; ept_q <= '0;
    end else begin
      if (ev_first_fail) begin
        sf_q  <= 1'b1;
        fft_q <= cur_tap;
      end
      if (ev_open) begin
        sp_q  <= 1'b1;
        spt_q <= cur_tap;
        fpt_q <= cur_tap;
      end
      if (ev_close) begin
        ep_q  <= 1'b1;
        ept_q <= cur_tap - 1'b1;
      end
      if (rej) begin
        spt_q <= cur_tap;
        ep_q  <= 1'b0;
      end
    end
  end

  // R5
  reject_moves_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej |=> (spt_q == $past(cur_tap)) && !ep_q);
  // R7
  first_edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_q && sp_q && step) |=> $stable(fft_q) && $stable(fpt_q));
endmodule

// File: rtl/tune_fix_engine.sv
module tune_fix_engine
  import tfe_pkg::*;
#(
  parameter int TAP_W      = TFE_TAP_W,
  parameter int WORD_W     = 32,
  parameter int SEL_W      = 3,
  parameter int ITER_SHORT = 128,
  parameter int ITER_LONG  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              long_run,
  input  logic [TAP_W-1:0]  hw_start_tap,
  input  logic [TAP_W-1:0]  hw_end_tap,
  input  logic [TAP_W-1:0]  hw_cur_tap,
  input  logic [TAP_W-1:0]  thr_hi,
  input  logic [TAP_W-1:0]  thr_lo,
  input  logic [TAP_W-1:0]  fix_ofs,
  output logic              word_req,
  output logic [SEL_W-1:0]  word_sel,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word_data,
  output logic              busy,
  output logic              done,
  output logic [TAP_W-1:0]  tap_out
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [SEL_W-1:0] LASTW_S = SEL_W'(ITER_SHORT / WORD_W - 1);
  localparam logic [SEL_W-1:0] LASTW_L = SEL_W'(ITER_LONG / WORD_W - 1);
  localparam logic [BIT_W-1:0] LASTB   = BIT_W'(WORD_W - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_REQ, ST_SCAN, ST_FALL, ST_FIN} st_t;
  st_t st;

  logic [SEL_W-1:0]  wsel;
  logic [BIT_W-1:0]  bitn;
  logic [WORD_W-1:0] word_q;
  tap_t c_q, hi_q, lo_q, ofs_q, tap_q;
  logic long_q, need_q;
  tap_t last_tap_now, cur_tap;
  logic need_now, step, acc, ff_seen, fp_seen;
  tap_t acc_tap, ff_tap, fp_tap;
  logic [SEL_W-1:0] lastw;

  assign last_tap_now = long_run ? tap_t'(ITER_LONG - 1) : tap_t'(ITER_SHORT - 1);
  assign need_now = tfe_need(hw_start_tap, hw_end_tap, thr_hi, last_tap_now);
  assign lastw    = long_q ? LASTW_L : LASTW_S;
  assign step     = (st == ST_SCAN);
  assign cur_tap  = tap_t'(wsel) * tap_t'(WORD_W) + tap_t'(bitn);

  tfe_scan u_scan (
    .clk(clk), .rst_n(rst_n), .clr(st == ST_IDLE && start), .step(step),
    .pass_bit(word_q[bitn]), .cur_tap(cur_tap), .thr_hi(hi_q), .thr_lo(lo_q),
    .acc(acc), .acc_tap(acc_tap), .ff_seen(ff_seen), .fp_seen(fp_seen),
    .ff_tap(ff_tap), .fp_tap(fp_tap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; wsel <= '0; bitn <= '0; word_q <= '0;
      c_q <= '0; hi_q <= '0; lo_q <= '0; ofs_q <= '0; tap_q <= '0;
      long_q <= 1'b0; need_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          c_q <= hw_cur_tap; hi_q <= thr_hi; lo_q <= thr_lo; ofs_q <= fix_ofs;
          long_q <= long_run; need_q <= need_now; wsel <= '0; bitn <= '0;
          if (need_now) st <= ST_REQ;
          else begin
            tap_q <= hw_cur_tap;
            st    <= ST_FIN;
          end
        end
        ST_REQ: if (word_vld) begin
          word_q <= word_data;
          bitn   <= '0;
          st     <= ST_SCAN;
        end
        ST_SCAN: begin
          if (acc) begin
            tap_q <= acc_tap;
            st    <= ST_FIN;
          end else if (bitn == LASTB) begin
            if (wsel == lastw) st <= ST_FALL;
            else begin
              wsel <= wsel + 1'b1;
              st   <= ST_REQ;
            end
          end else bitn <= bitn + 1'b1;
        end
        ST_FALL: begin
          tap_q <= (ff_seen && fp_seen) ? tfe_edge_pick(ff_tap, fp_tap, ofs_q) : c_q;
          st    <= ST_FIN;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign word_req = (st == ST_REQ);
  assign word_sel = wsel;
  assign busy     = (st != ST_IDLE);
  assign done     = (st == ST_FIN);
  assign tap_out  = tap_q;

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  busy_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
  // R3
  word_sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_req |-> (word_sel <= lastw));
  // R3
  word_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_req && !word_vld) |=> word_req && $stable(word_sel));
  // R4
  accept_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> done && !word_req && (tap_out == $past(acc_tap)));
  // R2
  keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !need_q) |-> (tap_out == c_q));
endmodule

// File: tb/sim_tune_fix_engine.sv
module sim_tune_fix_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, long_run = 1'b0;
  logic [7:0] hw_start_tap = '0, hw_end_tap = '0, hw_cur_tap = '0;
  logic [7:0] thr_hi = '0, thr_lo = '0, fix_ofs = '0;
  logic word_req, busy, done, word_vld = 1'b0;
  logic [2:0] word_sel;
  logic [31:0] word_data = '0;
  logic [7:0] tap_out;

  logic [255:0] bm = '0;
  int n_checks = 0, n_fail = 0;
  int words_seen = 0;
  bit order_bad = 0;

  always #2.5 clk = ~clk;

  tune_fix_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .long_run(long_run),
    .hw_start_tap(hw_start_tap), .hw_end_tap(hw_end_tap), .hw_cur_tap(hw_cur_tap),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .fix_ofs(fix_ofs),
    .word_req(word_req), .word_sel(word_sel), .word_vld(word_vld),
    .word_data(word_data), .busy(busy), .done(done), .tap_out(tap_out)
  );

  // bitmap responder: one-cycle request/valid handshake
  initial begin
    forever begin
      @(negedge clk);
      if (word_req && !word_vld) begin
        if (int'(word_sel) != words_seen) order_bad = 1;
        word_data = bm[word_sel*32 +: 32];
        word_vld  = 1'b1;
        words_seen++;
      end else word_vld = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench model of the correction rules
  function automatic void model(input logic [255:0] b, input bit lng,
      input int s, input int e, input int c, input int hi, input int lo,
      input int ofs, output int tap, output int nw, output bit need);
    int n, last, fft, fpt, spt, ept, w, ed;
    bit sf, sp, ep;
    n = lng ? 256 : 128;
    last = n - 1;
    need = (s == 0) || (e == last) || (e == last - 1) || (((e - s) & 255) >= hi);
    nw = 0; tap = c;
    if (!need) return;
    sf = 0; sp = 0; ep = 0; fft = 0; fpt = 0; spt = 0; ept = 0;
    for (int t = 0; t < n; t++) begin
      if (!b[t] && !sf) begin sf = 1; fft = t; end
      else if (b[t] && sf && !sp) begin sp = 1; spt = t; fpt = t; end
      else if (!b[t] && sf && sp && !ep) begin ep = 1; ept = (t - 1) & 255; end
      else if (b[t] && sp && ep) begin
        w = (ept - spt) & 255;
        if (w >= hi || w < lo) begin spt = t; ep = 0; end
        else begin
          tap = (spt + w / 2) & 255;
          nw = t / 32 + 1;
          return;
        end
      end
    end
    nw = n / 32;
    if (sf && sp) begin
      ed = (fft + (fpt - fft) / 2) & 255;
      if (ed - 1 > ofs) tap = (ed - ofs) & 255;
      else tap = (ed + ofs) & 255;
    end
  endfunction

  task automatic run_case(input string tag, input bit lng, input int s, input int e,
      input int c, input int hi, input int lo, input int ofs);
    int etap, enw, cyc;
    bit need, saw_busy;
    model(bm, lng, s, e, c, hi, lo, ofs, etap, enw, need);
    @(negedge clk);
    long_run = lng; hw_start_tap = 8'(s); hw_end_tap = 8'(e); hw_cur_tap = 8'(c);
    thr_hi = 8'(hi); thr_lo = 8'(lo); fix_ofs = 8'(ofs);
    words_seen = 0; order_bad = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; saw_busy = busy;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (!done) saw_busy = saw_busy && busy;
    end
    // R9: busy held across the run and in the done cycle
    check(saw_busy && busy && done, "R9 busy/done", int'(busy), 1);
    if (!need) check(tap_out == 8'(etap), "R2 keep hw tap", tap_out, etap);
    else check(tap_out == 8'(etap), {"R4/R5/R6/R7/R8 tap ", tag}, tap_out, etap);
    // R3 / R4: word count and order
    check(words_seen == enw && !order_bad, {"R3 words ", tag}, words_seen, enw);
    @(negedge clk);
    // R9: single pulse, busy drops, tap held
    check(!done && !busy && tap_out == 8'(etap), "R9 pulse/hold", int'(done), 0);
  endtask

  function automatic logic [255:0] mk(input int lo_fail, input int hi_fail);
    logic [255:0] v;
    v = '1;
    for (int t = lo_fail; t <= hi_fail; t++) v[t] = 1'b0;
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int seed, t, len;
    seed = 11;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !done && !word_req && tap_out == 0, "R1 reset state", int'(busy), 0);
    rst_n = 1'b1;

    // R2: window trusted
    bm = '0;
    run_case("keep", 0, 10, 40, 77, 50, 3, 9);
    // R6: no fail bit
    bm = '1;
    run_case("allpass", 0, 0, 60, 33, 40, 3, 9);
    // R8: fail with no later pass
    bm = '0;
    run_case("allfail", 1, 0, 60, 91, 40, 3, 9);
    // R7: single edge, offset subtracted
    bm = mk(20, 30);
    run_case("edge_sub", 0, 0, 100, 5, 40, 3, 10);
    // R7: edge near zero, offset added
    bm = mk(0, 3);
    run_case("edge_add", 0, 0, 100, 5, 200, 3, 10);
    // R5 then R4: bubble discarded, next window accepted in word 1
    bm = '1;
    for (int i = 0; i <= 4; i++) bm[i] = 1'b0;
    bm[7] = 1'b0; bm[31] = 1'b0;
    run_case("bubble", 0, 0, 100, 5, 40, 3, 10);
    // R4: reopening pass on last tap, window accepted
    bm = mk(0, 126); for (int i = 10; i <= 29; i++) bm[i] = 1'b1;
    run_case("last_acc", 0, 0, 126, 5, 40, 3, 10);
    // R7: same map, window merged, fallback on last bit
    run_case("last_fall", 0, 0, 126, 5, 15, 3, 3);
    // R7: first pass on last tap
    bm = mk(0, 126);
    run_case("late_pass", 0, 0, 126, 5, 40, 3, 10);
    // R2 boundary: end at last-1 with long pass forces correction
    bm = mk(40, 45);
    run_case("end_m2", 1, 30, 254, 5, 250, 3, 10);

    // constrained random maps
    for (int k = 0; k < 80; k++) begin
      bit lng;
      int s, e, n;
      lng = $urandom_range(0, 1);
      n = lng ? 256 : 128;
      bm = '0;
      t = $urandom_range(0, 4);
      for (int i = 0; i < t; i++) bm[i] = 1'b1;
      while (t < 256) begin
        len = $urandom_range(1, 6);
        t += len;
        len = $urandom_range(1, 40);
        for (int i = 0; i < len && t < 256; i++) begin bm[t] = 1'b1; t++; end
      end
      if ($urandom_range(0, 1) == 1) s = 0;
      else s = $urandom_range(1, 60);
      e = s + $urandom_range(0, 60);
      if (e > n - 3) e = n - 3;
      run_case("rand", lng, s, e, $urandom_range(0, 255),
               $urandom_range(8, 45), $urandom_range(1, 8), $urandom_range(2, 20));
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule